// File: doc/BRIEF.md
# Serial Read Token Chain Controller

This block sits in each of several identical parallel-in, serial-out buffers that share one serial shift clock and one serial data line. A single read token circulates among the buffers. Only the holder may take a word from its own storage, shift it out and enable its driver onto the shared line. After its last bit goes out, it passes the token on with a one-cycle pulse. Chained in a ring, the buffers therefore deliver their words interleaved, one whole word from each in turn.

Two pins are sampled while reset is held. The lead strap picks which buffer holds the token first. The token input, if tied high, selects stand-alone operation. In stand-alone operation the buffer always owns the line, shifts words back to back, ignores its token input, and reuses its token output pin to carry an almost-empty/almost-full status flag. Storage is outside this block, which sees only a word, an "available" indication and a pop strobe. The shift clock is `clk_i` qualified by `shift_en_i`.

Top module: `tok_chain_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `tok_o`, `sdo_oe_o` and `word_pop_o` are low. `first_n_i` and `tok_i` are captured on clock edges while `rst_ni` is low.
- R2: In chained operation (`tok_i` low during reset), the device whose `first_n_i` was low during reset holds the token first, and only that device pops the first word. Devices strapped high wait for a token.
- R3: A token holder pops (`word_pop_o` high) only in a cycle with `shift_en_i` and `word_avail_i` high. It loads `word_i` at that edge, and `sdo_oe_o` is high from the next cycle.
- R4: A loaded word goes out one bit per shift edge, WORD_W bits in all. If `msb_first_i` is 1 in the load cycle, bit WORD_W-1 goes out first; if it is 0, bit 0 goes out first. `sdo_o` is low whenever `sdo_oe_o` is low.
- R5: In chained operation, the shift edge that sends the last bit drops `sdo_oe_o` and raises `tok_o` for exactly one clock cycle. `tok_o` is never high while `sdo_oe_o` is high.
- R6: In chained operation, a device that sees `tok_i` high at a clock edge becomes the holder. It can pop no earlier than the next shift edge.
- R7: A holder with no word available keeps the token. It leaves `sdo_oe_o` and `tok_o` low and pops nothing until a word arrives.
- R8: A clock edge with `shift_en_i` low changes neither `sdo_o` nor `sdo_oe_o`.
- R9: In stand-alone operation (`tok_i` high during reset), the device always holds the token and ignores `tok_i`. `tok_o` equals `flag_i`. If a word is available at the last-bit edge, the next word loads at that same edge with no gap in `sdo_oe_o`.
- R10: In a ring of chained devices, at most one `sdo_oe_o` is high in any cycle. Words are popped in ring order, one per device per turn, starting from the lead device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| first_n_i | input | 1 | Lead strap, low = starts with token, sampled in reset |
| tok_i | input | 1 | Token pulse from previous device; high during reset = stand-alone |
| shift_en_i | input | 1 | Serial shift enable, shared by all devices |
| msb_first_i | input | 1 | Bit order for the word being loaded |
| word_i | input | WORD_W | Next word from local storage |
| word_avail_i | input | 1 | Local storage holds a word |
| flag_i | input | 1 | Almost-empty/almost-full flag, shown on tok_o in stand-alone |
| word_pop_o | output | 1 | Word taken from storage this cycle |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Drive enable for the shared serial line |
| tok_o | output | 1 | Token pulse to next device, or status flag in stand-alone |

## Verification
The bench drives a three-device ring with irregular shift enables and per-word random bit order. It rebuilds the expected interleaved bit stream from the pop order and compares it bit by bit. A handoff one cycle late or early would show up as two enables at once or as a pop out of turn. A wrong bit order or count would corrupt the stream. In one run the middle device is starved, to show that the token is held rather than skipped or lost. A second reset moves the lead strap to the last device, to catch a holder that is fixed rather than sampled. A stand-alone instance, whose token input toggles freely, must mirror its flag input on `tok_o` and never drop its enable while words remain. A design that dropped it would open a one-bit gap between words.

// File: rtl/tok_chain_pkg.sv
package tok_chain_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SOLO  = 1'b1
  } tok_mode_e;
endpackage

// File: rtl/tok_mode_cap.sv
module tok_mode_cap
  import tok_chain_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      first_n_i,
  input  logic      tok_i,
  output logic      run_o,
  output tok_mode_e mode_o,
  output logic      lead_o
);
  tok_mode_e mode_q;
  logic      lead_q;
  logic      run_q;

  // straps are captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= tok_i ? MODE_SOLO : MODE_CHAIN;
      lead_q <= ~first_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign lead_o = lead_q;
endmodule

// File: rtl/tok_owner.sv
module tok_owner
  import tok_chain_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  tok_mode_e mode_i,
  input  logic      lead_i,
  input  logic      tok_i,
  input  logic      done_i,
  output logic      own_o,
  output logic      pulse_o
);
  logic own_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (!run_i) begin
        own_q <= lead_i | (mode_i == MODE_SOLO);
      end else if (mode_i == MODE_SOLO) begin
        own_q <= 1'b1;
      end else if (done_i) begin
        own_q   <= 1'b0;
        pulse_q <= 1'b1;
      end else if (tok_i) begin
        own_q <= 1'b1;
      end
    end
  end

  assign own_o   = own_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/tok_word_shifter.sv
module tok_word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              own_i,
  input  logic              b2b_i,
  input  logic              word_avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              msb_first_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, msb_q;
  logic              last, adv, load;

  assign last = (cnt_q == LAST);
  assign adv  = shift_en_i & busy_q;
  assign load = shift_en_i & own_i & word_avail_i & (~busy_q | (last & b2b_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      msb_q  <= 1'b0;
    end else if (load) begin
      sh_q   <= word_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      msb_q  <= msb_first_i;
    end else if (adv) begin
      if (last) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= msb_q ? (sh_q << 1) : (sh_q >> 1);
    end
  end

  assign pop_o  = load;
  assign busy_o = busy_q;
  assign done_o = adv & last;
  assign sdo_o  = busy_q & (msb_q ? sh_q[WORD_W-1] : sh_q[0]);
endmodule

// File: rtl/tok_chain_ctrl.sv
module tok_chain_ctrl
  import tok_chain_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_n_i,
  input  logic              tok_i,
  input  logic              shift_en_i,
  input  logic              msb_first_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_avail_i,
  input  logic              flag_i,
  output logic              word_pop_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              tok_o
);
  logic      run_w, lead_w, own_w, pulse_w, busy_w, done_w, solo_w;
  tok_mode_e mode_w;

  tok_mode_cap u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_n_i(first_n_i),
    .tok_i    (tok_i),
    .run_o    (run_w),
    .mode_o   (mode_w),
    .lead_o   (lead_w)
  );

  assign solo_w = (mode_w == MODE_SOLO);

  tok_owner u_owner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .mode_i (mode_w),
    .lead_i (lead_w),
    .tok_i  (tok_i),
    .done_i (done_w),
    .own_o  (own_w),
    .pulse_o(pulse_w)
  );

  tok_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_en_i),
    .own_i       (own_w),
    .b2b_i       (solo_w),
    .word_avail_i(word_avail_i),
    .word_i      (word_i),
    .msb_first_i (msb_first_i),
    .pop_o       (word_pop_o),
    .busy_o      (busy_w),
    .sdo_o       (sdo_o),
    .done_o      (done_w)
  );

  assign sdo_oe_o = busy_w;
  assign tok_o    = run_w & (solo_w ? flag_i : pulse_w);
endmodule

// File: rtl/tok_chain_chk.sv
module tok_chain_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic shift_en_i,
  input logic word_avail_i,
  input logic word_pop_o,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic tok_o,
  input logic run_i,
  input logic solo_i,
  input logic own_i
);
  assert_pop_needs_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_pop_o |-> (word_avail_i && shift_en_i));

  assert_pulse_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !solo_i && tok_o) |=> !tok_o);

  assert_handoff_on_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !solo_i && $fell(sdo_oe_o)) |-> tok_o);

  assert_hold_without_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> ($stable(sdo_oe_o) && $stable(sdo_o)));

  assert_drive_needs_token_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !solo_i && sdo_oe_o) |-> own_i);
endmodule

bind tok_chain_ctrl tok_chain_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_en_i  (shift_en_i),
  .word_avail_i(word_avail_i),
  .word_pop_o  (word_pop_o),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .tok_o       (tok_o),
  .run_i       (run_w),
  .solo_i      (solo_w),
  .own_i       (own_w)
);

// File: tb/tok_chain_ctrl_tb_top.sv
`timescale 1ns/1ps
module tok_chain_ctrl_tb_top;
  localparam int W  = 4;
  localparam int NW = 8;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic se, dir;
  logic first_n [ND];
  logic [W-1:0] word [ND];
  logic avail [ND];
  logic pop [ND], sdo [ND], oe [ND], tok [ND];

  logic s_tok, s_avail, s_flag, s_pop, s_sdo, s_oe, s_tok_o;
  logic [W-1:0] s_word;

  int nchk = 0, nfail = 0;
  int idx [ND], lim [ND], pend [ND];
  int nxt;
  int s_idx, s_lim, s_pend;
  bit exp_q[$];
  bit s_q[$];
  bit prev_ok, prev_se, s_prev_oe;
  logic prev_oe [ND], prev_sdo [ND], prev_pop [ND], prev_tok [ND];
  logic s_prev_sdo;
  bit se_rand;

  always #2 clk = ~clk;

  for (genvar k = 0; k < ND; k++) begin : g_dev
    tok_chain_ctrl #(.WORD_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .first_n_i(first_n[k]),
      .tok_i(tok[(k + ND - 1) % ND]), .shift_en_i(se), .msb_first_i(dir),
      .word_i(word[k]), .word_avail_i(avail[k]), .flag_i(1'b0),
      .word_pop_o(pop[k]), .sdo_o(sdo[k]), .sdo_oe_o(oe[k]), .tok_o(tok[k])
    );
  end

  tok_chain_ctrl #(.WORD_W(W)) solo_i (
    .clk_i(clk), .rst_ni(rst_n), .first_n_i(1'b1), .tok_i(s_tok),
    .shift_en_i(se), .msb_first_i(dir), .word_i(s_word),
    .word_avail_i(s_avail), .flag_i(s_flag), .word_pop_o(s_pop),
    .sdo_o(s_sdo), .sdo_oe_o(s_oe), .tok_o(s_tok_o)
  );

  function automatic logic [W-1:0] word_of(int k, int i);
    return W'((k * 7 + i * 5 + 3) ^ (i << 1));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_word(ref bit q[$], input logic [W-1:0] w, input logic d);
    for (int b = 0; b < W; b++) q.push_back(d ? w[W-1-b] : w[b]);
  endtask

  task automatic step();
    int n;
    @(negedge clk);
    for (int k = 0; k < ND; k++) begin idx[k] += pend[k]; pend[k] = 0; end
    s_idx += s_pend; s_pend = 0;
    se  = se_rand ? (($urandom % 4) != 0) : 1'b1;
    dir = 1'($urandom % 2);
    for (int k = 0; k < ND; k++) begin
      word[k]  = word_of(k, idx[k]);
      avail[k] = (idx[k] < lim[k]);
    end
    s_word  = word_of(5, s_idx);
    s_avail = (s_idx < s_lim);
    s_flag  = 1'($urandom % 2);
    s_tok   = rst_n ? 1'($urandom % 2) : 1'b1;
    #1;
    if (!rst_n) begin prev_ok = 0; return; end
    n = 0;
    for (int k = 0; k < ND; k++) n += int'(oe[k]);
    chk(n <= 1, "R10 single driver", n, 1);
    for (int k = 0; k < ND; k++) begin
      if (se && oe[k]) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected bit", int'(sdo[k]), -1);
        else chk(sdo[k] == exp_q.pop_front(), "R4 serial bit", int'(sdo[k]), int'(!sdo[k]));
      end
      if (!oe[k]) chk(sdo[k] == 1'b0, "R4 idle line low", int'(sdo[k]), 0);
    end
    for (int k = 0; k < ND; k++) if (pop[k]) begin
      chk(k == nxt, "R6 R2 pop order", k, nxt);
      chk(avail[k] && se, "R3 pop qualified", int'(avail[k]), 1);
      push_word(exp_q, word[k], dir);
      nxt = (k + 1) % ND;
      pend[k] = 1;
    end
    for (int k = 0; k < ND; k++) if (tok[k]) begin
      chk(!(prev_ok && prev_tok[k]), "R5 pulse width", 2, 1);
      chk(!oe[k], "R5 no enable with pulse", int'(oe[k]), 0);
    end
    if (prev_ok) begin
      for (int k = 0; k < ND; k++) begin
        if (prev_pop[k]) chk(oe[k], "R3 enable after load", int'(oe[k]), 1);
        if (!prev_se) chk(oe[k] == prev_oe[k] && sdo[k] == prev_sdo[k],
                          "R8 hold without shift", int'(oe[k]), int'(prev_oe[k]));
      end
      if (!prev_se) chk(s_oe == s_prev_oe && s_sdo == s_prev_sdo,
                        "R8 solo hold", int'(s_oe), int'(s_prev_oe));
      if (s_prev_oe && !s_oe) chk(s_idx >= s_lim, "R9 no gap between words", s_idx, s_lim);
    end
    chk(s_tok_o == s_flag, "R9 flag on token pin", int'(s_tok_o), int'(s_flag));
    if (se && s_oe) begin
      if (s_q.size() == 0) chk(0, "R9 unexpected solo bit", int'(s_sdo), -1);
      else chk(s_sdo == s_q.pop_front(), "R9 solo bit", int'(s_sdo), int'(!s_sdo));
    end
    if (s_pop) begin push_word(s_q, s_word, dir); s_pend = 1; end
    for (int k = 0; k < ND; k++) begin
      prev_oe[k] = oe[k]; prev_sdo[k] = sdo[k]; prev_pop[k] = pop[k]; prev_tok[k] = tok[k];
    end
    s_prev_oe = s_oe; s_prev_sdo = s_sdo; prev_se = se; prev_ok = 1;
  endtask

  task automatic do_reset(int lead);
    rst_n = 1'b0;
    for (int k = 0; k < ND; k++) begin
      first_n[k] = (k != lead); idx[k] = 0; pend[k] = 0;
    end
    s_idx = 0; s_pend = 0; nxt = lead;
    exp_q.delete(); s_q.delete();
    repeat (4) step();
    for (int k = 0; k < ND; k++)
      chk(!oe[k] && !tok[k] && !pop[k], "R1 quiet in reset", int'(oe[k] | tok[k] | pop[k]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < ND; k++)
      chk(!oe[k] && !tok[k] && !pop[k], "R1 quiet after release", int'(oe[k] | tok[k] | pop[k]), 0);
    chk(!s_oe && !s_pop, "R1 solo quiet after release", int'(s_oe | s_pop), 0);
  endtask

  task automatic run_to_end(int cap);
    int c = 0;
    bit busy = 1;
    while (busy && c < cap) begin
      step();
      c++;
      busy = (exp_q.size() != 0) || (s_q.size() != 0) || (s_idx + s_pend < s_lim);
      for (int k = 0; k < ND; k++)
        if (idx[k] + pend[k] < lim[k] || oe[k]) busy = 1;
    end
    for (int k = 0; k < ND; k++) chk(idx[k] == lim[k], "R10 all words delivered", idx[k], lim[k]);
    chk(exp_q.size() == 0, "R10 stream drained", exp_q.size(), 0);
    chk(s_idx == s_lim, "R9 solo words delivered", s_idx, s_lim);
  endtask

  initial begin
    rst_n = 1'b1; se = 1'b0; dir = 1'b0; se_rand = 0;
    for (int k = 0; k < ND; k++) begin first_n[k] = 1'b1; word[k] = '0; avail[k] = 1'b0; end
    s_tok = 1'b1; s_flag = 1'b0; s_avail = 1'b0; s_word = '0;
    prev_ok = 0; prev_se = 1;
    #1;
    // phase 1: lead at device 0, middle device starved (R7)
    lim[0] = 2; lim[1] = 0; lim[2] = 2; s_lim = NW;
    do_reset(0);
    repeat (30) step();
    chk(idx[0] + pend[0] == 1, "R7 lead popped once", idx[0] + pend[0], 1);
    chk(idx[2] + pend[2] == 0, "R7 token not skipped", idx[2] + pend[2], 0);
    for (int k = 0; k < ND; k++)
      chk(!oe[k] && !tok[k], "R7 starved holder quiet", int'(oe[k] | tok[k]), 0);
    for (int k = 0; k < ND; k++) lim[k] = NW;
    se_rand = 1;
    run_to_end(3000);
    // phase 2: lead moved to device 2 (R2)
    for (int k = 0; k < ND; k++) lim[k] = 3;
    s_lim = 4;
    se_rand = 0;
    do_reset(2);
    se_rand = 1;
    run_to_end(3000);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule